// File: doc/BRIEF.md
# Performance monitor counter unit

This block counts clock cycles and core events so that software can profile a processor. It holds three 32-bit counters. One counts only clock cycles, either on every clock or once every 64 clocks. The other two each count an event that software picks with an 8-bit code. The code can point at one of the core's event strobe lines, at an external trace line, or at the clock itself. One control and status register carries a single enable for the whole unit, the reset commands, the prescaler switch, the interrupt enables, the overflow flags and both event codes.

Software reaches the four registers through a simple port with a 2-bit select, a write strobe and a read bus that is valid in the same cycle. The counters cannot be stopped one at a time. To stop one event counter, software points its code at the trace line and holds that line low. Every counter that wraps from all ones to zero sets its own overflow flag. The three flags, each gated by its enable, share one interrupt line. Software clears a flag by writing 1 to it, so it can read the control register and write the same value back to clear exactly the flags it saw.

Top module: `pmu_counter_unit`

## Requirements
- R1: After reset, all three counters, the control register and irq are zero.
- R2: reg_sel picks the register for both read and write: 0 is control, 1 is the cycle counter, 2 is event counter 0, and 3 is event counter 1. reg_rdata shows the selected register combinationally. A write takes effect at the clock edge.
- R3: Control bit 0 is the only run switch. While it is 0, no counter changes unless software writes it or resets it.
- R4: While the unit is running, the cycle counter adds one on each clock if control bit 3 is 0. If bit 3 is 1, it adds one once every 64 clocks, on each clock when a free-running 6-bit divider (it advances only while the unit runs) is at 63.
- R5: Bits 27:20 of control select the event for event counter 0, and bits 19:12 select it for event counter 1. A code n below 32 counts each clock where evt_in[n] is high. Code 0x20 counts each clock where trace_in is high. Code 0xFF counts every clock. Any other code never counts.
- R6: Writing 1 to control bit 1 zeroes both event counters. Writing 1 to bit 2 zeroes the cycle counter. Either reset wins over an increment in the same clock. Both bits always read as 0.
- R7: A write to a counter loads the written value, even if an increment falls in the same clock.
- R8: Overflow flags sit at bit 8 (event counter 0), bit 9 (event counter 1) and bit 10 (cycle counter). A flag sets when its counter wraps from 0xFFFFFFFF to 0, whatever the state of its interrupt enable. If a wrap and a clear land in the same clock, the flag stays set.
- R9: Writing 1 to a flag bit clears that flag, and writing 0 leaves it as it is. Writing back a value just read from control clears the flags that were set and leaves every other field unchanged.
- R10: irq is high exactly when some flag is set and its enable is set: bit 4 for event counter 0, bit 5 for event counter 1, bit 6 for the cycle counter.
- R11: Control bits 31:28, 11 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| evt_in | input | 32 | Event strobe lines from the core, one per event code |
| trace_in | input | 1 | External trace line, counted under code 0x20 |
| irq | output | 1 | Shared overflow interrupt |

## Verification
A counter that has drifted shows up on reg_rdata in the cycle after the edge where it went wrong, but only while that counter is selected. For this reason the bench keeps the select pointed at the register under test and compares it on every clock. A flag or enable in the wrong state shows on irq one clock after the wrap or the write that caused it. A prescaler divider out of phase appears only after up to 64 clocks, as a cycle count that is off by one. The wrap tests therefore load counters close to all ones, so the flags get exercised in a handful of clocks.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  // control register layout (software decodes these positions)
  localparam int CTRL_EN_BIT      = 0;
  localparam int CTRL_RST_EVT_BIT = 1;
  localparam int CTRL_RST_CYC_BIT = 2;
  localparam int CTRL_PRESC_BIT   = 3;
  localparam int CTRL_IEN_LSB     = 4;
  localparam int CTRL_OVF_LSB     = 8;
  localparam int CTRL_SEL1_LSB    = 12;
  localparam int CTRL_SEL0_LSB    = 20;
  localparam int CODE_W           = 8;
  localparam int NUM_CNT          = 3;   // 0: event 0, 1: event 1, 2: cycles

  localparam logic [CODE_W-1:0] CODE_TRACE  = 8'h20;
  localparam logic [CODE_W-1:0] CODE_CYCLES = 8'hFF;

  typedef enum logic [1:0] {
    RSEL_CTRL = 2'd0,
    RSEL_CYC  = 2'd1,
    RSEL_EV0  = 2'd2,
    RSEL_EV1  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [CODE_W-1:0]  sel0;
    logic [CODE_W-1:0]  sel1;
    logic [NUM_CNT-1:0] ien;
    logic               presc;
    logic               en;
  } ctrl_t;

  // register select that addresses counter i
  function automatic logic [1:0] sel_of(int i);
    case (i)
      0:       return 2'(RSEL_EV0);
      1:       return 2'(RSEL_EV1);
      default: return 2'(RSEL_CYC);
    endcase
  endfunction

  function automatic ctrl_t ctrl_from_word(logic [31:0] w);
    ctrl_t c;
    c.en    = w[CTRL_EN_BIT];
    c.presc = w[CTRL_PRESC_BIT];
    c.ien   = w[CTRL_IEN_LSB +: NUM_CNT];
    c.sel1  = w[CTRL_SEL1_LSB +: CODE_W];
    c.sel0  = w[CTRL_SEL0_LSB +: CODE_W];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_image(ctrl_t c, logic [NUM_CNT-1:0] ovf);
    logic [31:0] r;
    r = '0;
    r[CTRL_EN_BIT]                = c.en;
    r[CTRL_PRESC_BIT]             = c.presc;
    r[CTRL_IEN_LSB +: NUM_CNT]    = c.ien;
    r[CTRL_OVF_LSB +: NUM_CNT]    = ovf;
    r[CTRL_SEL1_LSB +: CODE_W]    = c.sel1;
    r[CTRL_SEL0_LSB +: CODE_W]    = c.sel0;
    return r;
  endfunction

  // write-one-to-clear with set taking priority
  function automatic logic [NUM_CNT-1:0] flag_next(logic [NUM_CNT-1:0] cur,
                                                   logic [NUM_CNT-1:0] clr,
                                                   logic [NUM_CNT-1:0] set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/pmu_evt_sel.sv
module pmu_evt_sel
  import pmu_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic [CODE_W-1:0]    code,
  input  logic [NUM_LINES-1:0] evt_in,
  input  logic                 trace_in,
  output logic                 hit
);
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  always_comb begin
    if (code == CODE_CYCLES)
      hit = 1'b1;
    else if (code == CODE_TRACE)
      hit = trace_in;
    else if (32'(code) < NUM_LINES)
      hit = evt_in[code[IDX_W-1:0]];
    else
      hit = 1'b0;
  end
endmodule

// File: rtl/pmu_prescaler.sv
module pmu_prescaler #(
  parameter int DIV_LOG2 = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  logic [DIV_LOG2-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   div_q <= '0;
    else if (run) div_q <= div_q + 1'b1;
  end

  assign tick = run && (&div_q);

  // R4
  presc_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic         wrap
);
  logic [W:0] sum_w;

  assign sum_w = {1'b0, q} + (W+1)'(1);
  assign wrap  = inc && !ld && !clr && sum_w[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (ld)  q <= ld_val;
    else if (clr) q <= '0;
    else if (inc) q <= sum_w[W-1:0];
  end

  // R7
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> q == $past(ld_val));
  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ld) |=> q == '0);
  // R3
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !clr && !inc) |=> $stable(q));
endmodule

// File: rtl/pmu_counter_unit.sv
module pmu_counter_unit
  import pmu_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int EVT_LINES = 32,
  parameter int PRESC_LOG2 = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           reg_sel,
  input  logic                 reg_wr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [EVT_LINES-1:0] evt_in,
  input  logic                 trace_in,
  output logic                 irq
);
  ctrl_t              ctrl_q;
  logic [NUM_CNT-1:0] ovf_q;
  logic [NUM_CNT-1:0] cnt_ld, cnt_clr, cnt_inc, cnt_wrap, evt_hit;
  logic [CNT_W-1:0]   cnt_q [NUM_CNT];
  logic               ctrl_wr, clr_evt, clr_cyc, presc_tick, cyc_step;
  logic [NUM_CNT-1:0] ovf_clr;

  assign ctrl_wr  = reg_wr && (reg_sel == 2'(RSEL_CTRL));
  assign clr_evt  = ctrl_wr && reg_wdata[CTRL_RST_EVT_BIT];
  assign clr_cyc  = ctrl_wr && reg_wdata[CTRL_RST_CYC_BIT];
  assign ovf_clr  = ctrl_wr ? reg_wdata[CTRL_OVF_LSB +: NUM_CNT] : '0;

  pmu_prescaler #(.DIV_LOG2(PRESC_LOG2)) i_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (ctrl_q.en),
    .tick (presc_tick)
  );

  assign cyc_step = ctrl_q.en && (!ctrl_q.presc || presc_tick);

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    if (i < 2) begin : g_evt
      pmu_evt_sel #(.NUM_LINES(EVT_LINES)) i_sel (
        .code    ((i == 0) ? ctrl_q.sel0 : ctrl_q.sel1),
        .evt_in  (evt_in),
        .trace_in(trace_in),
        .hit     (evt_hit[i])
      );
      assign cnt_clr[i] = clr_evt;
      assign cnt_inc[i] = ctrl_q.en && evt_hit[i];
    end else begin : g_cyc
      assign evt_hit[i] = 1'b1;
      assign cnt_clr[i] = clr_cyc;
      assign cnt_inc[i] = cyc_step;
    end

    assign cnt_ld[i] = reg_wr && (reg_sel == sel_of(i));

    pmu_counter #(.W(CNT_W)) i_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (cnt_ld[i]),
      .ld_val(reg_wdata[CNT_W-1:0]),
      .clr   (cnt_clr[i]),
      .inc   (cnt_inc[i]),
      .q     (cnt_q[i]),
      .wrap  (cnt_wrap[i])
    );

    // R8
    flag_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wrap[i] |=> ovf_q[i]);
    // R9
    flag_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_clr[i] && !cnt_wrap[i]) |=> !ovf_q[i]);
    // R9
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q[i] && !ovf_clr[i]) |=> ovf_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ovf_q  <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_from_word(reg_wdata);
      ovf_q <= flag_next(ovf_q, ovf_clr, cnt_wrap);
    end
  end

  always_comb begin
    case (reg_sel)
      2'(RSEL_CTRL): reg_rdata = ctrl_image(ctrl_q, ovf_q);
      2'(RSEL_CYC):  reg_rdata = 32'(cnt_q[2]);
      2'(RSEL_EV0):  reg_rdata = 32'(cnt_q[0]);
      default:       reg_rdata = 32'(cnt_q[1]);
    endcase
  end

  assign irq = |(ovf_q & ctrl_q.ien);

  // R11
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'(RSEL_CTRL)) |-> (reg_rdata[31:28] == 4'd0 && !reg_rdata[11] && !reg_rdata[7]));
  // R6
  rst_bits_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'(RSEL_CTRL)) |-> reg_rdata[2:1] == 2'b00);
endmodule

// File: tb/test_pmu_counter_unit.sv
module test_pmu_counter_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] evt_in = '0;
  logic        trace_in = 1'b0;
  logic        irq;

  int n_chk = 0, n_bad = 0, n_clk = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pmu_counter_unit i_pmu_counter_unit (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
    .trace_in(trace_in), .irq(irq)
  );

  // ---------------- behavioural reference ----------------
  bit [31:0] m_ev0, m_ev1, m_cyc;
  int        m_div;
  bit        m_run, m_slow;
  bit [7:0]  m_code0, m_code1;
  bit        m_ie0, m_ie1, m_iec;
  bit        m_f0, m_f1, m_fc;

  function automatic bit m_counts(bit [7:0] code, bit [31:0] ev, bit tr);
    if (code == 8'hFF) return 1'b1;
    if (code == 8'h20) return tr;
    if (code < 8'd32)  return ev[code];
    return 1'b0;
  endfunction

  function automatic bit [31:0] m_read(bit [1:0] s);
    bit [31:0] v;
    case (s)
      2'd1: return m_cyc;
      2'd2: return m_ev0;
      2'd3: return m_ev1;
      default: begin
        v = 32'd0;
        v = v | 32'(m_run) | (32'(m_slow) << 3);
        v = v | (32'(m_ie0) << 4) | (32'(m_ie1) << 5) | (32'(m_iec) << 6);
        v = v | (32'(m_f0) << 8) | (32'(m_f1) << 9) | (32'(m_fc) << 10);
        v = v | (32'(m_code1) << 12) | (32'(m_code0) << 20);
        return v;
      end
    endcase
  endfunction

  function automatic bit m_irq();
    return (m_f0 && m_ie0) || (m_f1 && m_ie1) || (m_fc && m_iec);
  endfunction

  task automatic model_edge();
    bit slow_tick, h0, h1, hc, cw, w0, w1, wc;
    slow_tick = m_run && (m_div == 63);
    if (m_run) m_div = (m_div + 1) % 64;
    h0 = m_run && m_counts(m_code0, evt_in, trace_in);
    h1 = m_run && m_counts(m_code1, evt_in, trace_in);
    hc = m_run && (!m_slow || slow_tick);
    cw = reg_wr && reg_sel == 2'd0;
    w0 = 0; w1 = 0; wc = 0;
    if (reg_wr && reg_sel == 2'd2) m_ev0 = reg_wdata;
    else if (cw && reg_wdata[1]) m_ev0 = 0;
    else if (h0) begin w0 = (m_ev0 == 32'hFFFF_FFFF); m_ev0 = m_ev0 + 1; end
    if (reg_wr && reg_sel == 2'd3) m_ev1 = reg_wdata;
    else if (cw && reg_wdata[1]) m_ev1 = 0;
    else if (h1) begin w1 = (m_ev1 == 32'hFFFF_FFFF); m_ev1 = m_ev1 + 1; end
    if (reg_wr && reg_sel == 2'd1) m_cyc = reg_wdata;
    else if (cw && reg_wdata[2]) m_cyc = 0;
    else if (hc) begin wc = (m_cyc == 32'hFFFF_FFFF); m_cyc = m_cyc + 1; end
    if (cw) begin
      if (reg_wdata[8])  m_f0 = 0;
      if (reg_wdata[9])  m_f1 = 0;
      if (reg_wdata[10]) m_fc = 0;
      m_run = reg_wdata[0]; m_slow = reg_wdata[3];
      m_ie0 = reg_wdata[4]; m_ie1 = reg_wdata[5]; m_iec = reg_wdata[6];
      m_code1 = reg_wdata[19:12]; m_code0 = reg_wdata[27:20];
    end
    m_f0 = m_f0 | w0; m_f1 = m_f1 | w1; m_fc = m_fc | wc;
  endtask

  // ---------------- checking helpers ----------------
  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick1();
    @(posedge clk);
    model_edge();
    #2;
    chk("R2", reg_rdata, m_read(reg_sel));
    chk("R10", 32'(irq), 32'(m_irq()));
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) tick1();
  endtask

  task automatic wreg(bit [1:0] s, bit [31:0] v);
    reg_sel = s; reg_wr = 1'b1; reg_wdata = v;
    tick1();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic look(bit [1:0] s);
    reg_sel = s;
    #1;
  endtask

  function automatic bit [31:0] ctrl_word(bit en, bit slow, bit [2:0] ie, bit [7:0] c0, bit [7:0] c1);
    return 32'(en) | (32'(slow) << 3) | (32'(ie) << 4) | (32'(c1) << 12) | (32'(c0) << 20);
  endfunction

  // watchdog
  always @(posedge clk) begin
    n_clk++;
    if (n_clk > 100000 && !done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", n_clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit [31:0] snap, a0, a1, ac;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1: reset state on every register
    for (int s = 0; s < 4; s++) begin
      look(2'(s));
      chk("R1", reg_rdata, 32'd0);
    end
    chk("R1", 32'(irq), 32'd0);

    // R5: instruction code 7 on counter 0, code 5 on counter 1
    wreg(2'd0, ctrl_word(1, 0, 3'b111, 8'h07, 8'h05));
    evt_in = 32'h0000_0080; ticks(10);
    evt_in = 32'h0000_0020; ticks(5);
    evt_in = 32'h0000_00A0; ticks(3);
    evt_in = '0;
    look(2'd2); chk("R5", reg_rdata, 32'd13);
    look(2'd3); chk("R5", reg_rdata, 32'd8);

    // R4: cycle counter counts every clock, 18 ticks since enable
    look(2'd1); chk("R4", reg_rdata, 32'd18);

    // R4: prescaled cycle counting
    wreg(2'd1, 32'd0);
    wreg(2'd0, ctrl_word(1, 1, 3'b000, 8'h07, 8'h05));
    look(2'd1); ticks(200);
    chk("R4", reg_rdata, m_cyc);
    chk("R4", 32'(reg_rdata >= 3 && reg_rdata <= 4), 32'd1);

    // R5: park on trace code, unknown code never counts
    wreg(2'd0, ctrl_word(1, 0, 3'b000, 8'h20, 8'h40));
    evt_in = '1; trace_in = 1'b0;
    look(2'd2); a0 = reg_rdata; ticks(12);
    chk("R5", reg_rdata, a0);
    trace_in = 1'b1; ticks(6); trace_in = 1'b0;
    chk("R5", reg_rdata, a0 + 6);
    look(2'd3); a1 = reg_rdata; ticks(4);
    chk("R5", reg_rdata, a1);

    // R3: global disable freezes everything
    wreg(2'd0, ctrl_word(0, 0, 3'b000, 8'hFF, 8'hFF));
    trace_in = 1'b1;
    look(2'd2); a0 = reg_rdata;
    look(2'd3); a1 = reg_rdata;
    look(2'd1); ac = reg_rdata;
    ticks(20);
    chk("R3", reg_rdata, ac);
    look(2'd2); chk("R3", reg_rdata, a0);
    look(2'd3); chk("R3", reg_rdata, a1);
    evt_in = '0; trace_in = 1'b0;

    // R8/R10: wraps set flags; cycle flag set although its enable is off
    wreg(2'd2, 32'hFFFF_FFFB);
    wreg(2'd3, 32'hFFFF_FFF9);
    wreg(2'd1, 32'hFFFF_FFF6);
    wreg(2'd0, ctrl_word(1, 0, 3'b011, 8'hFF, 8'hFF));
    look(2'd0); ticks(12);
    chk("R8", reg_rdata & 32'h700, 32'h700);
    chk("R10", 32'(irq), 32'd1);

    // R10: all enables off, irq falls although flags remain
    wreg(2'd0, ctrl_word(1, 0, 3'b000, 8'hFF, 8'hFF));
    chk("R10", 32'(irq), 32'd0);
    chk("R8", reg_rdata & 32'h700, 32'h700);
    wreg(2'd0, ctrl_word(1, 0, 3'b100, 8'hFF, 8'hFF));
    chk("R10", 32'(irq), 32'd1);

    // R9: read-modify-write clears flags, keeps the rest
    snap = reg_rdata;
    wreg(2'd0, snap);
    chk("R9", reg_rdata, snap & ~32'h700);
    chk("R9", 32'(irq), 32'd0);

    // R8: wrap and clear in the same clock, flag stays set
    wreg(2'd2, 32'hFFFF_FFFF);
    wreg(2'd0, ctrl_word(1, 0, 3'b001, 8'hFF, 8'hFF) | 32'h100);
    chk("R8", reg_rdata & 32'h100, 32'h100);
    chk("R10", 32'(irq), 32'd1);
    wreg(2'd0, ctrl_word(1, 0, 3'b001, 8'hFF, 8'hFF) | 32'h100);
    chk("R9", reg_rdata & 32'h100, 32'h0);

    // R6: reset bits zero their counters and read as zero
    ticks(5);
    wreg(2'd0, ctrl_word(1, 0, 3'b000, 8'hFF, 8'hFF) | 32'h2);
    chk("R6", reg_rdata & 32'h6, 32'h0);
    look(2'd2); chk("R6", reg_rdata, 32'd0);
    look(2'd3); chk("R6", reg_rdata, 32'd0);
    look(2'd1); a0 = reg_rdata;
    chk("R6", 32'(a0 > 32'd5), 32'd1);
    wreg(2'd0, ctrl_word(1, 0, 3'b000, 8'hFF, 8'hFF) | 32'h4);
    look(2'd1); chk("R6", reg_rdata, 32'd0);
    tick1(); chk("R6", reg_rdata, 32'd1);

    // R7: counter write coincides with an increment
    wreg(2'd2, 32'h0000_1234);
    chk("R7", reg_rdata, 32'h0000_1234);
    wreg(2'd1, 32'hABCD_0000);
    chk("R7", reg_rdata, 32'hABCD_0000);
    tick1(); chk("R7", reg_rdata, 32'hABCD_0001);

    // R11: all ones into control
    wreg(2'd0, 32'hFFFF_FFFF);
    chk("R11", reg_rdata, 32'h0FFF_F079);

    // R2: long mixed run with rotating selects
    for (int r = 0; r < 40; r++) begin
      evt_in = 32'(r * 37) ^ 32'h0000_00A5;
      trace_in = r[0];
      reg_sel = 2'(r);
      ticks(3);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule